// File: doc/BRIEF.md
# Magic Address Read-Sequence Detector

This block watches the control strobes and address of an asynchronous SRAM bus. The bus is sampled by the block's own clock, and a falling edge of the active-low chip enable marks the start of one access. The detector looks for six read addresses arriving one after another in a fixed order. When the last of the six is read with nothing else in between, it raises a one-cycle store request toward the nonvolatile sequencer.

Only chip-enable-controlled reads count as steps, and they count only with output enable low and write enable high. Any other access aborts a partial sequence: a read of an unrelated address, a read with output enable high, or a write (even a write to the next expected address). The one exception is a read of the first sequence address, which restarts the detector as though that read were step one. The sequencer holds the busy input high while it is storing. During that time every access is ignored and the detector stays idle.

Top module: `magic_seq_detect`

## Requirements
- R1: After reset `storeReq` is low and the detector is idle, so the first step of a new sequence is expected.
- R2: The low 16 address bits must match 0x4E38, 0xB1C7, 0x83E0, 0x7C1F, 0x703F and 0x8FC0 in that order. When the sixth one is accepted, `storeReq` is high for exactly one clock, in the cycle after the clock edge that samples that chip-enable fall.
- R3: A step is taken only at a chip-enable fall: `ceN` sampled high on one clock edge and low on the next. Address and strobe values at other times have no effect.
- R4: A step counts only if `oeN` is low and `weN` is high when the chip-enable fall is sampled.
- R5: A read of an address that is neither the next expected step nor the first sequence address returns the detector to idle, and no store is requested.
- R6: A write access (`weN` low at the chip-enable fall) returns the detector to idle, even when its address matches the next expected step.
- R7: A read with `oeN` high at the chip-enable fall returns the detector to idle.
- R8: A valid read of the first sequence address in the middle of a sequence leaves the detector waiting for the second step.
- R9: Address bit 16 is ignored by the comparison.
- R10: While `busy` is high, no store is requested and the detector is held idle. Accesses sampled during that time are ignored.
- R11: After a store request the detector is idle, so reading the sixth address again does not fire.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rstN | input | 1 | Active-low synchronous reset |
| addr | input | 17 | Bus address |
| ceN | input | 1 | Chip enable, active low |
| oeN | input | 1 | Output enable, active low |
| weN | input | 1 | Write enable, active low |
| busy | input | 1 | Store in progress; freezes detection |
| storeReq | output | 1 | One-cycle store request pulse |

## Verification
The hardest situation to reach from the ports is a long run of correct steps broken late by a look-alike access, such as a write or an output-enable-high read to the exact address expected next, or a fresh first-step read near the end. Uniform random addresses almost never get past step two. For that reason the random stimulus draws most addresses from the next expected step or the first step, and only rarely upsets the strobes. Directed cases also break full five-step prefixes at the sixth step in each way.

// File: rtl/magic_seq_pkg.sv
package magic_seq_pkg;
  localparam int ADDR_W    = 17;
  localparam int CMP_W     = 16;
  localparam int NUM_STEPS = 6;
  localparam int STEP_W    = $clog2(NUM_STEPS);

  typedef struct packed {
    logic clear;
    logic advance;
    logic restart;
  } seqStrobe_t;

  function automatic logic [CMP_W-1:0] stepAddr(input int idx);
    case (idx)
      0:       stepAddr = 16'h4E38;
      1:       stepAddr = 16'hB1C7;
      2:       stepAddr = 16'h83E0;
      3:       stepAddr = 16'h7C1F;
      4:       stepAddr = 16'h703F;
      default: stepAddr = 16'h8FC0;
    endcase
  endfunction
endpackage

// File: rtl/seq_datapath.sv
module seq_datapath
  import magic_seq_pkg::*;
#(
  parameter int ADDR_BITS = ADDR_W,
  parameter int CMP_BITS  = CMP_W,
  parameter int STEPS     = NUM_STEPS
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [ADDR_BITS-1:0] addr,
  input  logic                 ceN,
  input  logic                 oeN,
  input  logic                 weN,
  input  seqStrobe_t           strobes,
  output logic                 accessEvt,
  output logic                 readCyc,
  output logic                 matchNext,
  output logic                 matchFirst,
  output logic                 atLast
);
  localparam int SW = $clog2(STEPS);

  logic          ceDly;
  logic [SW-1:0] step;
  logic [CMP_BITS-1:0] cmpAddr;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ceDly <= 1'b1;
      step  <= '0;
    end else begin
      ceDly <= ceN;
      if (strobes.clear)        step <= '0;
      else if (strobes.restart) step <= SW'(1);
      else if (strobes.advance) step <= step + SW'(1);
    end
  end

  assign cmpAddr    = addr[CMP_BITS-1:0];
  assign accessEvt  = ceDly & ~ceN;
  assign readCyc    = ~oeN & weN;
  assign matchNext  = (cmpAddr == stepAddr(int'(step)));
  assign matchFirst = (cmpAddr == stepAddr(0));
  assign atLast     = (step == SW'(STEPS - 1));
endmodule

// File: rtl/seq_control.sv
module seq_control
  import magic_seq_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       busy,
  input  logic       accessEvt,
  input  logic       readCyc,
  input  logic       matchNext,
  input  logic       matchFirst,
  input  logic       atLast,
  output seqStrobe_t strobes,
  output logic       storeReq
);
  logic fire;

  always_comb begin
    strobes = '0;
    fire    = 1'b0;
    if (busy) begin
      strobes.clear = 1'b1;
    end else if (accessEvt) begin
      if (readCyc && matchNext) begin
        if (atLast) begin
          fire          = 1'b1;
          strobes.clear = 1'b1;
        end else begin
          strobes.advance = 1'b1;
        end
      end else if (readCyc && matchFirst) begin
        strobes.restart = 1'b1;
      end else begin
        strobes.clear = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) storeReq <= 1'b0;
    else       storeReq <= fire;
  end
endmodule

// File: rtl/magic_seq_detect.sv
module magic_seq_detect
  import magic_seq_pkg::*;
#(
  parameter int ADDR_BITS = ADDR_W,
  parameter int CMP_BITS  = CMP_W,
  parameter int STEPS     = NUM_STEPS
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [ADDR_BITS-1:0] addr,
  input  logic                 ceN,
  input  logic                 oeN,
  input  logic                 weN,
  input  logic                 busy,
  output logic                 storeReq
);
  seqStrobe_t strobes;
  logic accessEvt, readCyc, matchNext, matchFirst, atLast;

  seq_datapath #(.ADDR_BITS(ADDR_BITS), .CMP_BITS(CMP_BITS), .STEPS(STEPS)) u_dp (
    .clk(clk), .rstN(rstN), .addr(addr), .ceN(ceN), .oeN(oeN), .weN(weN),
    .strobes(strobes), .accessEvt(accessEvt), .readCyc(readCyc),
    .matchNext(matchNext), .matchFirst(matchFirst), .atLast(atLast)
  );

  seq_control u_ctl (
    .clk(clk), .rstN(rstN), .busy(busy), .accessEvt(accessEvt),
    .readCyc(readCyc), .matchNext(matchNext), .matchFirst(matchFirst),
    .atLast(atLast), .strobes(strobes), .storeReq(storeReq)
  );
endmodule

// File: rtl/magic_seq_chk.sv
module magic_seq_chk #(
  parameter int ADDR_BITS = 17
) (
  input logic                 clk,
  input logic                 rstN,
  input logic [ADDR_BITS-1:0] addr,
  input logic                 ceN,
  input logic                 oeN,
  input logic                 weN,
  input logic                 busy,
  input logic                 storeReq
);
  // R2
  pulse_width_chk: assert property (@(posedge clk) disable iff (!rstN)
    storeReq |=> !storeReq);

  // R2
  last_addr_chk: assert property (@(posedge clk) disable iff (!rstN)
    storeReq |-> ($past(addr[15:0]) == 16'h8FC0));

  // R3
  ce_fall_chk: assert property (@(posedge clk) disable iff (!rstN)
    storeReq |-> (!$past(ceN) && $past(ceN, 2)));

  // R4
  read_strobe_chk: assert property (@(posedge clk) disable iff (!rstN)
    storeReq |-> (!$past(oeN) && $past(weN)));

  // R6
  write_no_fire_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!ceN && !weN) |=> !storeReq);

  // R10
  busy_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    busy |=> !storeReq);
endmodule

bind magic_seq_detect magic_seq_chk #(.ADDR_BITS(ADDR_BITS)) u_chk (
  .clk(clk), .rstN(rstN), .addr(addr), .ceN(ceN), .oeN(oeN),
  .weN(weN), .busy(busy), .storeReq(storeReq)
);

// File: tb/tb_magic_seq_detect.sv
module tb_magic_seq_detect;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [16:0] addr = '0;
  logic        ceN = 1'b1, oeN = 1'b1, weN = 1'b1, busy = 1'b0;
  logic        storeReq;

  int checks = 0, failures = 0;
  int mStep = 0;
  logic [15:0] seqTab [6] = '{16'h4E38, 16'hB1C7, 16'h83E0, 16'h7C1F, 16'h703F, 16'h8FC0};

  magic_seq_detect dut (.clk(clk), .rstN(rstN), .addr(addr), .ceN(ceN),
    .oeN(oeN), .weN(weN), .busy(busy), .storeReq(storeReq));

  always #2 clk = ~clk;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // expected pulse from the requirements; updates model step
  function automatic bit modelAccess(input logic [16:0] a, input bit oe, input bit we, input bit bsy);
    bit fire = 0;
    if (bsy) mStep = 0;                                        // R10
    else if (!oe && we && a[15:0] == seqTab[mStep]) begin      // R2 R4 R9
      if (mStep == 5) begin fire = 1; mStep = 0; end           // R11
      else mStep++;
    end else if (!oe && we && a[15:0] == seqTab[0]) mStep = 1; // R8
    else mStep = 0;                                            // R5 R6 R7
    return fire;
  endfunction

  task automatic access(input logic [16:0] a, input bit oe, input bit we, input bit bsy, input string req);
    bit exp;
    @(negedge clk);
    addr = a; oeN = oe; weN = we; busy = bsy; ceN = 1'b0;
    exp = modelAccess(a, oe, we, bsy);
    @(negedge clk);
    chk(storeReq == exp, req, storeReq, exp);
    ceN = 1'b1;                       // R3: junk while chip enable high
    addr = 17'($urandom); oeN = 1'($urandom); weN = 1'($urandom);
    @(negedge clk);
    chk(storeReq == 1'b0, "R2", storeReq, 0);
  endtask

  task automatic prefix(input int n, input bit hi, input string req);
    for (int i = 0; i < n; i++) access({hi, seqTab[i]}, 0, 1, 0, req);
  endtask

  initial begin
    #(200000 * 4);
    failures++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    chk(storeReq == 1'b0, "R1", storeReq, 0);
    rstN = 1'b1;
    @(negedge clk);
    chk(storeReq == 1'b0, "R1", storeReq, 0);

    prefix(6, 0, "R1");                                        // R1 idle, R2 full sequence
    prefix(6, 1, "R9");                                        // R9 bit 16 set
    access({1'b0, seqTab[5]}, 0, 1, 0, "R11");                 // R11 no refire
    prefix(5, 0, "R5"); access(17'h01234, 0, 1, 0, "R5"); access({1'b0, seqTab[5]}, 0, 1, 0, "R5");
    prefix(5, 0, "R6"); access({1'b0, seqTab[5]}, 1, 0, 0, "R6"); access({1'b0, seqTab[5]}, 0, 1, 0, "R6");
    prefix(3, 0, "R6"); access({1'b0, seqTab[3]}, 0, 0, 0, "R6"); prefix(6, 0, "R6");
    prefix(5, 0, "R7"); access({1'b0, seqTab[5]}, 1, 1, 0, "R7"); access({1'b0, seqTab[5]}, 0, 1, 0, "R7");
    prefix(4, 0, "R8"); access({1'b0, seqTab[0]}, 0, 1, 0, "R8");
    for (int i = 1; i < 6; i++) access({1'b0, seqTab[i]}, 0, 1, 0, "R8");
    prefix(5, 0, "R10"); access({1'b0, seqTab[5]}, 0, 1, 1, "R10"); access({1'b0, seqTab[5]}, 0, 1, 0, "R10");
    prefix(6, 0, "R10");

    // R3: address wiggles with chip enable held low count once
    prefix(5, 0, "R3");
    @(negedge clk); addr = {1'b0, seqTab[5]}; oeN = 0; weN = 1; busy = 0; ceN = 0;
    void'(modelAccess({1'b0, seqTab[5]}, 0, 1, 0));
    @(negedge clk); chk(storeReq == 1'b1, "R3", storeReq, 1);
    for (int i = 0; i < 4; i++) begin
      @(negedge clk); chk(storeReq == 1'b0, "R3", storeReq, 0);
      addr = {1'b0, seqTab[i % 6]};
    end
    ceN = 1'b1; @(negedge clk);

    for (int n = 0; n < 4000; n++) begin
      int sel = $urandom_range(0, 99);
      logic [16:0] a;
      bit oe = ($urandom_range(0, 99) < 6);
      bit we = ($urandom_range(0, 99) >= 6);
      bit bs = ($urandom_range(0, 99) < 3);
      if (sel < 75)      a = {1'($urandom), seqTab[mStep]};
      else if (sel < 85) a = {1'($urandom), seqTab[0]};
      else if (sel < 93) a = {1'($urandom), seqTab[$urandom_range(0, 5)]};
      else               a = 17'($urandom);
      access(a, oe, we, bs, "R2");
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule